// File: doc/BRIEF.md
# Programmable Universal Switch Block

This block is a parameterized programmable interconnect point with `K` sides and `W` tracks on each side. Tracks on different sides can be joined only through switches that exist in a fixed topology chosen by a parameter. Each existing switch owns one configuration bit. Configuration is loaded serially through a single shift chain while a load strobe is high and is held unchanged once the strobe drops.

In operation every terminal output carries the OR of the inputs of all terminals that an enabled switch ties it to, so a net entering on one side appears on the far side one clock later. Three topologies are offered: a banded layout, in which a track reaches the same track and its two neighbours on every other side; a two-track twisted layout, repeated over pairs of tracks; and a mixed layout for odd widths, made of one banded core of width `f` followed by twisted pairs on the remaining tracks. The number of switches the chosen topology contains is available as a constant output.

Top module: `usb_fabric`

## Requirements
- R1: A synchronous active-high `rst` clears every configuration bit and drives `term_out` to zero on the next clock edge, whatever `term_in` carries.
- R2: Switches are numbered from 0 in this order: side pair (a, b) with a < b taken lexicographically, then the track on side a, then the track on side b. While `cfg_load` is high one bit of `cfg_bit` is taken per clock; after the number of loads equal to the switch count, the earliest of those bits enables switch 0 and the latest enables the last switch.
- R3: While `cfg_load` is low the configuration does not change, whatever `cfg_bit` does.
- R4: In the clock cycle following any cycle with `cfg_load` high, `term_out` is all zero.
- R5: With `cfg_load` low, `term_out` bit `s*W+t` (side s, track t, both counted from 0) equals, one clock after the inputs, the OR of `term_in` over every terminal joined to (s, t) by an enabled switch; terminals on the same side are never joined.
- R6: Banded topology (TOPO = 0): track p on one side and track q on another side share a switch exactly when |p - q| <= 1.
- R7: Banded topology holds 3W - 2 switches per side pair, K(K-1)/2 x (3W - 2) in total.
- R8: Twisted topology (TOPO = 1, even W): tracks 2g and 2g+1 form group g; for sides a < b, local track p (1 or 2) of a group joins local track p + (b - a) - 1 of the same group on side b, read as 1 when odd and 2 when even. No switch crosses groups.
- R9: Twisted topology holds W switches per side pair, K(K-1)/2 x W in total.
- R10: Mixed topology (TOPO = 2, odd W >= f): tracks 0 to f-1 follow the banded rule among themselves, tracks f and up follow the twisted rule in pairs, and no switch joins the two regions; f = (K + 3 - i)/3 with i in 1..6 and i = K mod 6 (6 when K is a multiple of 6).
- R11: `sw_count` equals the switch total of the selected topology at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe; shifts one configuration bit per cycle while high |
| cfg_bit | input | 1 | Serial configuration data |
| term_in | input | K*W | Terminal inputs, side s track t at bit s*W+t |
| term_out | output | K*W | Registered terminal outputs, same bit layout |
| sw_count | output | CNT_W | Number of switches in the selected topology |

## Verification
Three instances run side by side: banded with four sides and width three, mixed with seven sides and width five (core width three plus one twisted pair), and twisted with four sides and width two. A stream of all ones checks the full reach of each topology, while streams carrying a single one at many offsets enable one switch at a time and so expose any error in switch numbering or in which tracks a switch joins. Sparse random streams with random inputs test the OR merging of several sources onto one terminal, and short load bursts in mid-operation, plus toggling of the serial data while the strobe is low, separate the output blanking from the configuration hold.

// File: rtl/usb_pkg.sv
package usb_pkg;

    localparam int TOPO_BAND  = 0;
    localparam int TOPO_TWIST = 1;
    localparam int TOPO_MIXED = 2;

    // width of the banded core used by the mixed layout
    function automatic int core_width(input int k);
        int r;
        r = k % 6;
        if (r == 0) r = 6;
        return (k + 3 - r) / 3;
    endfunction

    // number of low tracks that follow the banded rule
    function automatic int band_tracks(input int topo, input int k, input int w);
        int c;
        if (topo == TOPO_BAND) return w;
        if (topo == TOPO_TWIST) return 0;
        c = core_width(k);
        return (c < w) ? c : w;
    endfunction

    // switch presence, sides a < b and tracks p, q all counted from 0
    function automatic bit linked(input int topo, input int k, input int w,
                                  input int a, input int p, input int b, input int q);
        int bt;
        int lp;
        int lq;
        bt = band_tracks(topo, k, w);
        if (p < bt && q < bt) return (p - q <= 1) && (q - p <= 1);
        if (p < bt || q < bt) return 1'b0;
        if ((p - bt) / 2 != (q - bt) / 2) return 1'b0;
        if (((p - bt) / 2) * 2 + bt + 1 >= w) return 1'b0;
        lp = (p - bt) % 2;
        lq = (q - bt) % 2;
        return lq == (1 - ((lp + b - a) % 2));
    endfunction

    function automatic int switch_total(input int topo, input int k, input int w);
        int n;
        n = 0;
        for (int a = 0; a < k; a++)
            for (int b = a + 1; b < k; b++)
                for (int p = 0; p < w; p++)
                    for (int q = 0; q < w; q++)
                        if (linked(topo, k, w, a, p, b, q)) n++;
        return n;
    endfunction

endpackage

// File: rtl/usb_cfg_chain.sv
module usb_cfg_chain #(
    parameter int NSW = 42
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [NSW-1:0] cfg
);

    typedef struct packed {
        logic [NSW-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;
    logic [NSW-1:0] shifted;

    generate
        if (NSW > 1) begin : g_long
            assign shifted = {st_q.bits[NSW-2:0], din};
        end else begin : g_single
            assign shifted = din;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.bits = shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg = st_q.bits;

endmodule

// File: rtl/usb_xbar.sv
module usb_xbar
    import usb_pkg::*;
#(
    parameter int K    = 4,
    parameter int W    = 3,
    parameter int TOPO = TOPO_BAND,
    parameter int NSW  = 42,
    localparam int KW  = K * W
) (
    input  logic [NSW-1:0] cfg,
    input  logic [KW-1:0]  tin,
    output logic [KW-1:0]  tout
);

    always_comb begin
        logic [KW-1:0] acc;
        int n;
        acc = '0;
        n   = 0;
        for (int a = 0; a < K; a++)
            for (int b = a + 1; b < K; b++)
                for (int p = 0; p < W; p++)
                    for (int q = 0; q < W; q++)
                        if (linked(TOPO, K, W, a, p, b, q)) begin
                            if (cfg[NSW-1-n]) begin
                                acc[a*W+p] = acc[a*W+p] | tin[b*W+q];
                                acc[b*W+q] = acc[b*W+q] | tin[a*W+p];
                            end
                            n++;
                        end
        tout = acc;
    end

endmodule

// File: rtl/usb_fabric.sv
module usb_fabric
    import usb_pkg::*;
#(
    parameter int K     = 4,
    parameter int W     = 3,
    parameter int TOPO  = TOPO_BAND,
    parameter int CNT_W = 16,
    localparam int KW   = K * W,
    localparam int NSW  = switch_total(TOPO, K, W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [KW-1:0]    term_in,
    output logic [KW-1:0]    term_out,
    output logic [CNT_W-1:0] sw_count
);

    typedef struct packed {
        logic [KW-1:0] outv;
    } out_t;

    out_t st_d, st_q;
    logic [NSW-1:0] cfg_q;
    logic [KW-1:0]  merged;

    usb_cfg_chain #(.NSW(NSW)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_load),
        .din      (cfg_bit),
        .cfg      (cfg_q)
    );

    usb_xbar #(.K(K), .W(W), .TOPO(TOPO), .NSW(NSW)) u_xbar (
        .cfg  (cfg_q),
        .tin  (term_in),
        .tout (merged)
    );

    always_comb begin
        st_d = st_q;
        st_d.outv = cfg_load ? '0 : merged;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign term_out = st_q.outv;
    assign sw_count = CNT_W'(NSW);

endmodule

// File: rtl/usb_fabric_chk.sv
module usb_fabric_chk #(
    parameter int K   = 4,
    parameter int W   = 3,
    parameter int NSW = 42
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_load,
    input logic           cfg_bit,
    input logic [K*W-1:0] term_in,
    input logic [K*W-1:0] term_out,
    input logic [NSW-1:0] cfg_q
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (term_out == '0 && cfg_q == '0));

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (cfg_q[0] == $past(cfg_bit)));

    generate
        if (NSW > 1) begin : g_walk
            assert_shift_walk_R2: assert property (@(posedge clk) disable iff (rst)
                cfg_load |=> (cfg_q[NSW-1:1] == $past(cfg_q[NSW-2:0])));
        end
    endgenerate

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_q));

    assert_load_blank_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (term_out == '0));

    assert_quiet_inputs_R5: assert property (@(posedge clk) disable iff (rst)
        (term_in == '0) |=> (term_out == '0));

endmodule

bind usb_fabric usb_fabric_chk #(.K(K), .W(W), .NSW(NSW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_bit  (cfg_bit),
    .term_in  (term_in),
    .term_out (term_out),
    .cfg_q    (cfg_q)
);

// File: tb/sim_usb_fabric.sv
`timescale 1ns/1ps

module sim_ref #(
    parameter int K    = 4,
    parameter int W    = 3,
    parameter int TOPO = 0
) (
    input logic           clk,
    input logic           rst,
    input logic           load,
    input logic           cbit,
    input logic [K*W-1:0] tin,
    input logic [K*W-1:0] tout,
    input logic [15:0]    cnt
);

    int checks = 0;
    int errs   = 0;
    bit ring[$];
    logic [K*W-1:0] expv;
    string tag;
    bit started = 0;
    bit cnt_done = 0;

    function automatic int core_f(int k);
        int i;
        i = k % 6;
        if (i == 0) i = 6;
        return (k + 3 - i) / 3;
    endfunction

    // 1-based sides a<b and tracks p, q
    function automatic bit joins(int a, int p, int b, int q);
        int bw, pp, qq, t;
        bw = (TOPO == 0) ? W : (TOPO == 1) ? 0 : core_f(K);
        if (p <= bw && q <= bw) return (p - q) * (p - q) <= 1;
        if (p <= bw || q <= bw) return 0;
        if ((p - bw - 1) / 2 != (q - bw - 1) / 2) return 0;
        pp = (p - bw - 1) % 2 + 1;
        qq = (q - bw - 1) % 2 + 1;
        t  = pp + (b - a) - 1;
        return qq == ((t % 2 == 1) ? 1 : 2);
    endfunction

    function automatic int formula_count();
        int pairs;
        pairs = K * (K - 1) / 2;
        if (TOPO == 0) return pairs * (3 * W - 2);
        if (TOPO == 1) return pairs * W;
        return pairs * (3 * core_f(K) - 2 + (W - core_f(K)));
    endfunction

    function automatic int enum_count();
        int n = 0;
        for (int a = 1; a <= K; a++)
            for (int b = a + 1; b <= K; b++)
                for (int p = 1; p <= W; p++)
                    for (int q = 1; q <= W; q++)
                        if (joins(a, p, b, q)) n++;
        return n;
    endfunction

    function automatic logic [K*W-1:0] predict();
        logic [K*W-1:0] r = '0;
        int n = 0;
        for (int a = 1; a <= K; a++)
            for (int b = a + 1; b <= K; b++)
                for (int p = 1; p <= W; p++)
                    for (int q = 1; q <= W; q++)
                        if (joins(a, p, b, q)) begin
                            if (ring[n]) begin
                                if (tin[(b-1)*W+q-1]) r[(a-1)*W+p-1] = 1'b1;
                                if (tin[(a-1)*W+p-1]) r[(b-1)*W+q-1] = 1'b1;
                            end
                            n++;
                        end
        return r;
    endfunction

    string topo_tag;
    initial topo_tag = (TOPO == 0) ? "R6" : (TOPO == 1) ? "R8" : "R10";

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            ring = {};
            for (int i = 0; i < formula_count(); i++) ring.push_back(1'b0);
            expv = '0;
            tag  = "R1";
        end else begin
            if (load) begin
                expv = '0;
                tag  = "R4";
                ring.push_back(cbit);
                void'(ring.pop_front());
            end else begin
                expv = predict();
                tag  = {"R2/R3/R5/", topo_tag};
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (tout !== expv) begin
                errs++;
                $display("FAIL %s K=%0d W=%0d out=%h expected=%h", tag, K, W, tout, expv);
            end
            if (!rst && !cnt_done) begin
                cnt_done = 1;
                checks++;
                if (int'(cnt) != formula_count()) begin
                    errs++;
                    $display("FAIL R11 K=%0d W=%0d count=%0d expected=%0d", K, W, cnt, formula_count());
                end
                checks++;
                if (enum_count() != formula_count()) begin
                    errs++;
                    $display("FAIL %s/R7/R9 rule total=%0d expected=%0d", topo_tag, enum_count(), formula_count());
                end
            end
        end
    end

endmodule

module sim_usb_fabric;

    logic clk = 0;
    always #4 clk = ~clk;

    logic rst = 1, load = 0, cbit = 0;
    logic [11:0] in0 = '0, out0;
    logic [34:0] in1 = '0, out1;
    logic [7:0]  in2 = '0, out2;
    logic [15:0] cnt0, cnt1, cnt2;
    bit finished = 0;

    localparam int LEN = 189;

    usb_fabric #(.K(4), .W(3), .TOPO(0)) u0 (
        .clk(clk), .rst(rst), .cfg_load(load), .cfg_bit(cbit),
        .term_in(in0), .term_out(out0), .sw_count(cnt0));
    usb_fabric #(.K(7), .W(5), .TOPO(2)) u1 (
        .clk(clk), .rst(rst), .cfg_load(load), .cfg_bit(cbit),
        .term_in(in1), .term_out(out1), .sw_count(cnt1));
    usb_fabric #(.K(4), .W(2), .TOPO(1)) u2 (
        .clk(clk), .rst(rst), .cfg_load(load), .cfg_bit(cbit),
        .term_in(in2), .term_out(out2), .sw_count(cnt2));

    sim_ref #(.K(4), .W(3), .TOPO(0)) r0 (.clk(clk), .rst(rst), .load(load), .cbit(cbit), .tin(in0), .tout(out0), .cnt(cnt0));
    sim_ref #(.K(7), .W(5), .TOPO(2)) r1 (.clk(clk), .rst(rst), .load(load), .cbit(cbit), .tin(in1), .tout(out1), .cnt(cnt1));
    sim_ref #(.K(4), .W(2), .TOPO(1)) r2 (.clk(clk), .rst(rst), .load(load), .cbit(cbit), .tin(in2), .tout(out2), .cnt(cnt2));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_in(bit zero);
        in0 = zero ? '0 : 12'($urandom);
        in1 = zero ? '0 : {3'($urandom), 32'($urandom)};
        in2 = zero ? '0 : 8'($urandom);
    endtask

    // kind 0: all ones, 1: single one at hot, 2: sparse random
    task automatic shift_stream(int len, int kind, int hot);
        for (int i = 0; i < len; i++) begin
            load = 1;
            cbit = (kind == 0) ? 1'b1 : (kind == 1) ? (i == hot) : ($urandom % 4 == 0);
            drive_in(0);
            tick();
        end
        load = 0;
    endtask

    // R3: serial data toggles while the strobe is low
    task automatic run(int n, bit zero);
        for (int i = 0; i < n; i++) begin
            cbit = 1'($urandom);
            drive_in(zero);
            tick();
        end
    endtask

    task automatic summary();
        int c, e;
        c = r0.checks + r1.checks + r2.checks;
        e = r0.errs + r1.errs + r2.errs;
        if (!finished) begin
            c++;
            e++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", c, e);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        summary();
    end

    initial begin
        drive_in(0);
        repeat (4) tick();          // R1: inputs active during reset
        rst = 0;
        run(6, 0);                  // R1: cleared configuration gives zero outputs
        shift_stream(LEN, 0, 0);    // every switch on
        run(20, 0);
        run(4, 1);
        foreach (hots[h]) begin     // R2: one switch at a time
            shift_stream(LEN, 1, hots[h]);
            run(8, 0);
        end
        shift_stream(LEN, 2, 0);
        run(30, 0);
        shift_stream(5, 2, 0);      // R4: short burst mid-operation
        run(10, 0);
        shift_stream(LEN, 2, 0);
        run(20, 0);
        finished = 1;
        summary();
    end

    int hots[12] = '{0, 1, 5, 13, 40, 100, 147, 150, 160, 170, 180, 188};

endmodule